// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a bank of external pins and turns activity on them into interrupt flags. Each pin has its own configuration word, written over a small register bus. That word selects one of five detection styles: the pin sitting low, the pin sitting high, a low-to-high transition, a high-to-low transition, or a transition in either direction. It can also switch detection off for that pin. Every pin passes through a synchroniser before detection, so the pins may be fully asynchronous to the block clock.

When a pin meets its condition, its bit in a shared status word is set. Software reads that word, services the pins it finds, and clears them by writing ones to the matching bit positions. A single interrupt output stays high for as long as any status bit is set. A level-configured pin whose condition is still true sets its flag again at once, so its interrupt cannot be cleared until the pin or the mode changes.

The bus is word addressed in bytes. The configuration word of pin n is at byte offset 4*n. The status word is at offset 0xA0. Read data appears one cycle after the request.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every status flag is 0, `irq_o` is low, and every configuration word reads as 0.
- R2: A write to byte offset 4*n (n below the pin count) stores bits 19:16 of the write data as pin n's mode code. A read of that offset returns the code in bits 19:16 and 0 in all other bits.
- R3: In mode 0x9, a low-to-high change of a pin sets its status flag. The flag and `irq_o` become visible after the third rising clock edge that follows the pin change, and not before.
- R4: In mode 0xA, a high-to-low change sets the flag and a low-to-high change does not.
- R5: In mode 0xB, a change in either direction sets the flag.
- R6: In mode 0xC the flag is set on every cycle the synchronised pin is high; in mode 0x8, on every cycle it is low. A clear written while the condition still holds leaves the flag set.
- R7: Mode 0x0 (written by storing a zero word) and every code other than 0x8, 0x9, 0xA, 0xB and 0xC detect nothing; toggling the pin leaves the flag clear.
- R8: A write to offset 0xA0 clears each status flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A flag falls only through such a write. Writing all ones clears every flag.
- R9: In an edge mode, when a new edge and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: `irq_o` is high exactly when at least one status flag is set. It only rises after a detection event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Combined interrupt, high while any flag is set |

## Verification
A pin change applied between clock edges is registered by two synchroniser stages and then by the status register. Its flag and `irq_o` are therefore due after the third rising edge. The latency test samples `irq_o` at the falling edges after the first, second and third rising edges, and expects low, low, high. A configuration or clear write is latched on one rising edge. A level condition re-sets the flag on the next edge. Read data is sampled at the falling edge after the request edge. For the same-cycle clear, the clear write is timed so that it lands on the third edge after the pin change, when the edge event is present.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int unsigned MODE_W   = 4;
  localparam int unsigned MODE_LSB = 16;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF    = 4'h0,
    MODE_LVL_LO = 4'h8,
    MODE_RISE   = 4'h9,
    MODE_FALL   = 4'hA,
    MODE_BOTH   = 4'hB,
    MODE_LVL_HI = 4'hC
  } irq_mode_e;

  typedef struct packed {
    logic lvl_lo;
    logic lvl_hi;
    logic rise;
    logic fall;
  } detect_sel_t;

  // unlisted codes fall through to no detection
  function automatic detect_sel_t decode_mode(logic [MODE_W-1:0] code);
    detect_sel_t sel;
    sel = '0;
    case (code)
      MODE_LVL_LO: sel.lvl_lo = 1'b1;
      MODE_LVL_HI: sel.lvl_hi = 1'b1;
      MODE_RISE:   sel.rise   = 1'b1;
      MODE_FALL:   sel.fall   = 1'b1;
      MODE_BOTH: begin
        sel.rise = 1'b1;
        sel.fall = 1'b1;
      end
      default: sel = '0;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pin_irq_cell.sv
module pin_irq_cell
  import pin_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              samp_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              prev_o,
  output logic              evt_o
);

  logic [MODE_W-1:0] mode_q;
  logic              prev_q;
  detect_sel_t       sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= samp_i;
      if (cfg_we_i) mode_q <= cfg_mode_i;
    end
  end

  assign sel = decode_mode(mode_q);

  assign evt_o = (sel.lvl_hi &  samp_i)
               | (sel.lvl_lo & ~samp_i)
               | (sel.rise   &  samp_i & ~prev_q)
               | (sel.fall   & ~samp_i &  prev_q);

  assign mode_o = mode_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                any_o
);

  logic [NUM_PINS-1:0] status_q;

  // set dominates a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign any_o    = |status_q;

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned STATUS_OFS  = 'hA0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                irq_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] CFG_END     = ADDR_W'(4 * NUM_PINS);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFS);

  logic [NUM_PINS-1:0]             samp_all;
  logic [NUM_PINS-1:0]             prev_all;
  logic [NUM_PINS-1:0]             evt;
  logic [NUM_PINS-1:0]             cfg_we;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode_all;
  logic [NUM_PINS-1:0]             clr_mask;
  logic [NUM_PINS-1:0]             status_q;
  logic [IDX_W-1:0]                idx;
  logic                            cfg_hit;
  logic                            status_hit;
  logic                            wr_en;
  logic                            rd_en;
  logic [31:0]                     rd_mux;
  logic [31:0]                     rdata_q;

  assign idx        = bus_addr_i[ADDR_W-1:2];
  assign cfg_hit    = (bus_addr_i < CFG_END) && (bus_addr_i[1:0] == 2'b00);
  assign status_hit = (bus_addr_i == STATUS_ADDR);
  assign wr_en      = bus_req_i &  bus_we_i;
  assign rd_en      = bus_req_i & ~bus_we_i;

  pin_irq_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (samp_all)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign cfg_we[n] = wr_en & cfg_hit & (idx == IDX_W'(n));

    pin_irq_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we[n]),
      .cfg_mode_i (bus_wdata_i[MODE_LSB +: MODE_W]),
      .samp_i     (samp_all[n]),
      .mode_o     (mode_all[n]),
      .prev_o     (prev_all[n]),
      .evt_o      (evt[n])
    );
  end

  assign clr_mask = (wr_en & status_hit) ? bus_wdata_i[NUM_PINS-1:0] : '0;

  pin_irq_status #(
    .NUM_PINS (NUM_PINS)
  ) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt),
    .clr_i    (clr_mask),
    .status_o (status_q),
    .any_o    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (status_hit) begin
      rd_mux[NUM_PINS-1:0] = status_q;
    end else if (cfg_hit) begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (idx == IDX_W'(n)) rd_mux[MODE_LSB +: MODE_W] = mode_all[n];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             irq_o,
  input logic [NUM_PINS-1:0]              status_q,
  input logic [NUM_PINS-1:0]              evt,
  input logic [NUM_PINS-1:0]              clr_mask,
  input logic [NUM_PINS-1:0]              samp_all,
  input logic [NUM_PINS-1:0]              prev_all,
  input logic [NUM_PINS-1:0][MODE_W-1:0]  mode_all
);

  logic past_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_vld <= 1'b0;
    else         past_vld <= 1'b1;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clean_chk: assert (status_q == '0 && !irq_o);
    end
  end

  // R8
  flag_falls_on_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld |-> (($past(status_q) & ~status_q & ~$past(clr_mask)) == '0));

  // R10
  irq_rise_after_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld && $rose(irq_o)) |-> $past(|evt));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin_chk
    // R9
    event_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[n] |=> status_q[n]);

    // R6
    level_high_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_all[n] == 4'hC && samp_all[n]) |=> status_q[n]);

    // R3
    rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_all[n] == 4'h9 && samp_all[n] && !prev_all[n]) |=> status_q[n]);

    // R7
    bad_code_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mode_all[n] inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC}) |-> !evt[n]);
  end

endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(
  .NUM_PINS (NUM_PINS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .status_q (status_q),
  .evt      (evt),
  .clr_mask (clr_mask),
  .samp_all (samp_all),
  .prev_all (prev_all),
  .mode_all (mode_all)
);

// File: tb/pin_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pin_irq_ctrl_tb;

  localparam int unsigned NUM_PINS = 32;
  localparam logic [7:0]  STS      = 8'hA0;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [NUM_PINS-1:0] pin_i = '0;
  logic                bus_req_i = 1'b0;
  logic                bus_we_i = 1'b0;
  logic [7:0]          bus_addr_i = '0;
  logic [31:0]         bus_wdata_i = '0;
  logic [31:0]         bus_rdata_o;
  logic                irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  pin_irq_ctrl u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (pin_i),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    d = bus_rdata_o;
    bus_req_i = 1'b0;
  endtask

  task automatic set_pin(input int n, input logic v);
    pin_i[n] = v;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_mode(input int n, input logic [3:0] m);
    bus_wr(8'(4 * n), {12'h0, m, 16'h0});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq_o), 32'h0);
    bus_rd(STS, d);          check("R1 status", d, 32'h0);
    bus_rd(8'd20, d);        check("R1 cfg5", d, 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    bus_wr(8'd28, 32'hFFFF_FFFF);
    bus_rd(8'd28, d);        check("R2 pin7 field only", d, 32'h000F_0000);
    bus_wr(8'd124, 32'h000B_0000);
    bus_rd(8'd124, d);       check("R2 pin31", d, 32'h000B_0000);
    bus_rd(8'd28, d);        check("R2 pin7 kept", d, 32'h000F_0000);
    set_mode(7, 4'h0); set_mode(31, 4'h0);
    bus_rd(8'd28, d);        check("R2 pin7 zero", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_mode(3, 4'h9);
    pin_i[3] = 1'b1;
    @(posedge clk_i); @(negedge clk_i); check("R3 edge1", 32'(irq_o), 32'h0);
    @(posedge clk_i); @(negedge clk_i); check("R3 edge2", 32'(irq_o), 32'h0);
    @(posedge clk_i); @(negedge clk_i); check("R3 edge3", 32'(irq_o), 32'h1);
    bus_rd(STS, d);          check("R3 status", d, 32'h8);
    bus_wr(STS, 32'h8);
    set_pin(3, 1'b0);
    bus_rd(STS, d);          check("R3 fall ignored", d, 32'h0);
    check("R10 irq low", 32'(irq_o), 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    set_mode(4, 4'hA);
    set_pin(4, 1'b1);
    bus_rd(STS, d);          check("R4 rise ignored", d, 32'h0);
    set_pin(4, 1'b0);
    bus_rd(STS, d);          check("R4 fall", d, 32'h10);
    bus_wr(STS, 32'hFFFF_FFFF);
  endtask

  task automatic t_both();
    logic [31:0] d;
    set_mode(5, 4'hB);
    set_pin(5, 1'b1);
    bus_rd(STS, d);          check("R5 rise", d, 32'h20);
    bus_wr(STS, 32'h20);
    bus_rd(STS, d);          check("R5 cleared", d, 32'h0);
    set_pin(5, 1'b0);
    bus_rd(STS, d);          check("R5 fall", d, 32'h20);
    bus_wr(STS, 32'h20);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_mode(6, 4'hC);
    set_pin(6, 1'b1);
    bus_rd(STS, d);          check("R6 high", d, 32'h40);
    bus_wr(STS, 32'h40);
    bus_rd(STS, d);          check("R6 reasserts", d, 32'h40);
    check("R10 irq held", 32'(irq_o), 32'h1);
    set_pin(6, 1'b0);
    bus_wr(STS, 32'h40);
    bus_rd(STS, d);          check("R6 released", d, 32'h0);
    set_mode(8, 4'h8);
    @(posedge clk_i); @(negedge clk_i);
    bus_rd(STS, d);          check("R6 low", d, 32'h100);
    set_mode(8, 4'h0);
    bus_wr(STS, 32'h100);
    bus_rd(STS, d);          check("R7 masked by zero", d, 32'h0);
  endtask

  task automatic t_bad_codes();
    logic [31:0] d;
    set_mode(9, 4'hD);
    set_mode(11, 4'h3);
    set_pin(9, 1'b1); set_pin(11, 1'b1);
    set_pin(9, 1'b0); set_pin(11, 1'b0);
    set_pin(12, 1'b1); set_pin(12, 1'b0);
    bus_rd(STS, d);          check("R7 no flags", d, 32'h0);
    check("R7 irq", 32'(irq_o), 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    set_mode(3, 4'h9); set_mode(5, 4'hB);
    set_pin(3, 1'b1); set_pin(5, 1'b1);
    bus_rd(STS, d);          check("R8 both set", d, 32'h28);
    bus_wr(STS, 32'h8);
    bus_rd(STS, d);          check("R8 partial", d, 32'h20);
    check("R10 irq one flag", 32'(irq_o), 32'h1);
    bus_wr(STS, 32'h0);
    bus_rd(STS, d);          check("R8 zero write", d, 32'h20);
    bus_wr(STS, 32'hFFFF_FFFF);
    bus_rd(STS, d);          check("R8 all ones", d, 32'h0);
    check("R10 irq none", 32'(irq_o), 32'h0);
    set_pin(3, 1'b0); set_pin(5, 1'b0);
    bus_wr(STS, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    set_mode(10, 4'hB);
    set_pin(10, 1'b1);
    bus_rd(STS, d);          check("R9 first", d, 32'h400);
    pin_i[10] = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    @(posedge clk_i); @(negedge clk_i);
    bus_wr(STS, 32'h400);    // lands with the fall event
    bus_rd(STS, d);          check("R9 kept", d, 32'h400);
    bus_wr(STS, 32'h400);
    bus_rd(STS, d);          check("R9 then clear", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cfg();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_bad_codes();
    t_w1c();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog all requirements act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule